// File: doc/BRIEF.md
# Wide Screen Signaling Inserter

This block generates the two-level wide screen signaling burst carried on line 23 of the first field in 625-line video. It watches the line counter and the field flag from the video timing chain. When the selected line of the first field begins and insertion is enabled, it captures the 14-bit payload and the clock select. After a fixed number of sample strobes it sends a self-made run-in, then a start code, then the payload. Each payload bit is biphase coded. No check bits are added. The output is a one-bit amplitude code (1 = white insertion level, 0 = black) plus an active flag, both for a downstream level mapper and filter.

Elements run at 5 MHz. A fractional phase accumulator steps once per sample strobe, with increment/modulus 5/27 for the 27 MHz clock or 10/59 for the 29.5 MHz clock. So each element lasts five or six samples, and the burst keeps the exact average rate.

The control is a three-state machine. `ST_IDLE` waits for a line change. `ST_WAIT` counts sample strobes up to the start offset. `ST_SEND` emits the elements. The transitions are as follows:
- arm: IDLE or any state goes to WAIT when the line number changes to line 23 of field 1 and insertion is enabled.
- drop: any state goes to IDLE on any other line change.
- launch: WAIT goes to SEND when the offset count completes.
- finish: SEND goes to IDLE after the last element.

Top module: `wss_inserter`

## Requirements
- R1: While reset is held and right after it is released, `wss_active` and `wss_level` are both 0.
- R2: A burst is sent only when the line number changes to 23 while `field_first` is 1 and `en_f1` is 1. In every other case `wss_active` stays 0 for that line.
- R3: `en_f2` has no effect. Setting it never starts a burst on either field, and it does not change a burst that `en_f1` has enabled.
- R4: Each burst begins with 29 run-in elements equal to 0x1F1C71C7, followed by 24 start-code elements equal to 0x1E3C1F. Both are sent most significant bit first.
- R5: Next come 84 payload elements. They take `wss_word[14:1]` starting with `wss_word[1]`, six elements per bit: a 1 is sent as 1,1,1,0,0,0 and a 0 as 0,0,0,1,1,1. Bits 20 to 15 and bit 0 of `wss_word` are ignored.
- R6: No further elements follow the 137th. After the burst, `wss_active` returns to 0, and `wss_level` is 0 whenever `wss_active` is 0.
- R7: The n-th active output sample (n from 0) carries element floor(n*5/27) when `clk_sel` = 0, and element floor(n*10/59) when `clk_sel` = 1. The burst is therefore 740 or 809 samples long.
- R8: The clock edge that first sees the new line number counts as strobe 0 if a strobe is present there. The first element appears after sample strobe START_OFS+1, counting only sample strobes.
- R9: `wss_word` and `clk_sel` are captured when the line changes. Changes to them later in the line do not affect the burst under way.
- R10: Outputs change only on clock edges where `sample_en` is 1. On other edges they hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sample-valid strobe |
| field_first | input | 1 | 1 during the first field |
| line_num | input | LINE_W | Current line number |
| en_f1 | input | 1 | Enables insertion in the first field |
| en_f2 | input | 1 | Second-field enable (ignored) |
| clk_sel | input | 1 | 0 = 27 MHz sample clock, 1 = 29.5 MHz square-pixel clock |
| wss_word | input | 21 | Payload register; bits 14:1 are used |
| wss_level | output | 1 | Amplitude code: 1 = insertion level, 0 = black |
| wss_active | output | 1 | High while a burst element is being output |

## Verification
The hardest case to reach is a change to the payload and clock select in the middle of a burst, while the sample strobe has gaps. That is when a design that reads its inputs live, or steps the accumulator on every clock, diverges from the captured frame. The bench runs a line where it inverts `wss_word` and flips `clk_sel` 200 strobes after the offset, and another line where it drops every third strobe. It compares every strobe against an element index computed from the rational rate, and it checks that the outputs hold on the edges without a strobe.

// File: rtl/wss_pkg.sv
package wss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SEND
    } wss_state_t;

    localparam int RUNIN_LEN    = 29;
    localparam int SYNC_LEN     = 24;
    localparam int PAY_BITS     = 14;
    localparam int ELEM_PER_BIT = 6;
    localparam int FRAME_LEN    = RUNIN_LEN + SYNC_LEN + PAY_BITS * ELEM_PER_BIT;

    localparam logic [RUNIN_LEN-1:0]    RUNIN_PAT = 29'h1F1C71C7;
    localparam logic [SYNC_LEN-1:0]     SYNC_PAT  = 24'h1E3C1F;
    localparam logic [ELEM_PER_BIT-1:0] CODE_ONE  = 6'b111000;
    localparam logic [ELEM_PER_BIT-1:0] CODE_ZERO = 6'b000111;

    // Element e of the burst sits at bit FRAME_LEN-1-e.
    function automatic logic [FRAME_LEN-1:0] build_frame(input logic [PAY_BITS-1:0] pay);
        logic [FRAME_LEN-1:0] f;
        f = '0;
        f[FRAME_LEN-1 -: RUNIN_LEN] = RUNIN_PAT;
        f[FRAME_LEN-1-RUNIN_LEN -: SYNC_LEN] = SYNC_PAT;
        for (int b = 0; b < PAY_BITS; b++) begin
            f[(PAY_BITS-1-b)*ELEM_PER_BIT +: ELEM_PER_BIT] = pay[b] ? CODE_ONE : CODE_ZERO;
        end
        return f;
    endfunction

endpackage

// File: rtl/wss_phase_acc.sv
module wss_phase_acc #(
    parameter int NUM_STD = 5,
    parameter int DEN_STD = 27,
    parameter int NUM_SQ  = 10,
    parameter int DEN_SQ  = 59
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic sq_sel,
    output logic tick
);
    localparam int DEN_MAX = (DEN_STD > DEN_SQ) ? DEN_STD : DEN_SQ;
    localparam int ACC_W   = $clog2(DEN_MAX);
    localparam int SUM_W   = ACC_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [SUM_W-1:0] num_sel, den_sel, sum;

    always_comb begin
        num_sel = sq_sel ? SUM_W'(NUM_SQ) : SUM_W'(NUM_STD);
        den_sel = sq_sel ? SUM_W'(DEN_SQ) : SUM_W'(DEN_STD);
        sum     = {1'b0, acc_q} + num_sel;
        tick    = step && (sum >= den_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= (sum >= den_sel) ? ACC_W'(sum - den_sel) : ACC_W'(sum);
        end
    end
endmodule

// File: rtl/wss_frame_mux.sv
module wss_frame_mux
    import wss_pkg::*;
#(
    parameter int IDX_W = $clog2(FRAME_LEN)
) (
    input  logic [PAY_BITS-1:0] pay,
    input  logic [IDX_W-1:0]    idx,
    output logic                elem
);
    logic [FRAME_LEN-1:0] frame;

    always_comb begin
        frame = build_frame(pay);
        elem  = 1'b0;
        for (int e = 0; e < FRAME_LEN; e++) begin
            if (idx == IDX_W'(e)) elem = frame[FRAME_LEN-1-e];
        end
    end
endmodule

// File: rtl/wss_inserter.sv
module wss_inserter
    import wss_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int LINE_SEL  = 23,
    parameter int START_OFS = 264,
    parameter int NUM_STD   = 5,
    parameter int DEN_STD   = 27,
    parameter int NUM_SQ    = 10,
    parameter int DEN_SQ    = 59
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              field_first,
    input  logic [LINE_W-1:0] line_num,
    input  logic              en_f1,
    input  logic              en_f2,
    input  logic              clk_sel,
    input  logic [20:0]       wss_word,
    output logic              wss_level,
    output logic              wss_active
);
    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam int OFS_W = $clog2(START_OFS + 1);

    wss_state_t            state_q, state_d;
    logic [LINE_W-1:0]     prev_line_q;
    logic [PAY_BITS-1:0]   pay_q;
    logic                  sq_q;
    logic [OFS_W-1:0]      ofs_cnt_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  line_chg, arm, tick, elem, ofs_done, last_elem;
    logic                  unused_inputs;

    assign unused_inputs = ^{en_f2, wss_word[20:15], wss_word[0]};

    assign line_chg  = (line_num != prev_line_q);
    assign arm       = line_chg && (line_num == LINE_W'(LINE_SEL)) && field_first && en_f1;
    assign ofs_done  = sample_en && (ofs_cnt_q == OFS_W'(START_OFS - 1));
    assign last_elem = tick && (idx_q == IDX_W'(FRAME_LEN - 1));

    wss_phase_acc #(
        .NUM_STD(NUM_STD), .DEN_STD(DEN_STD), .NUM_SQ(NUM_SQ), .DEN_SQ(DEN_SQ)
    ) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state_q != ST_SEND),
        .step   (sample_en && (state_q == ST_SEND)),
        .sq_sel (sq_q),
        .tick   (tick)
    );

    wss_frame_mux #(.IDX_W(IDX_W)) u_mux (
        .pay  (pay_q),
        .idx  (idx_q),
        .elem (elem)
    );

    // Next-state selection: arm / drop / launch / finish.
    always_comb begin
        state_d = state_q;
        if (line_chg) begin
            state_d = arm ? ST_WAIT : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_WAIT: if (ofs_done)  state_d = ST_SEND;
                ST_SEND: if (last_elem) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register and the counters it owns.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            prev_line_q <= '0;
            pay_q       <= '0;
            sq_q        <= 1'b0;
            ofs_cnt_q   <= '0;
            idx_q       <= '0;
        end else begin
            state_q     <= state_d;
            prev_line_q <= line_num;
            if (line_chg) begin
                ofs_cnt_q <= '0;
                idx_q     <= '0;
                if (arm) begin
                    pay_q <= wss_word[14:1];
                    sq_q  <= clk_sel;
                end
            end else if (state_q == ST_WAIT && sample_en && !ofs_done) begin
                ofs_cnt_q <= ofs_cnt_q + 1'b1;
            end else if (state_q == ST_SEND && tick && !last_elem) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Output register, updated on sample strobes only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wss_active <= 1'b0;
            wss_level  <= 1'b0;
        end else if (sample_en) begin
            wss_active <= (state_q == ST_SEND) && !line_chg;
            wss_level  <= (state_q == ST_SEND) && !line_chg && elem;
        end
    end
endmodule

// File: rtl/wss_inserter_chk.sv
module wss_inserter_chk #(
    parameter int LINE_W    = 10,
    parameter int LINE_SEL  = 23,
    parameter int FRAME_LEN = 137,
    parameter int NUM_STD   = 5,
    parameter int DEN_STD   = 27,
    parameter int NUM_SQ    = 10,
    parameter int DEN_SQ    = 59
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_en,
    input logic              field_first,
    input logic [LINE_W-1:0] line_num,
    input logic              wss_active,
    input logic              wss_level
);
    localparam int RUN_STD = (FRAME_LEN * DEN_STD + NUM_STD - 1) / NUM_STD;
    localparam int RUN_SQ  = (FRAME_LEN * DEN_SQ + NUM_SQ - 1) / NUM_SQ;
    localparam int MAX_RUN = (RUN_STD > RUN_SQ) ? RUN_STD : RUN_SQ;
    localparam int RUN_W   = $clog2(MAX_RUN + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (sample_en) begin
            run_q <= wss_active ? run_q + 1'b1 : '0;
        end
    end

    AST_BURST_LINE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wss_active) |-> (line_num == LINE_W'(LINE_SEL) && field_first)); // R2
    AST_RUNIN_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wss_active) |-> wss_level); // R4
    AST_BLACK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wss_active |-> !wss_level); // R6
    AST_BURST_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        wss_active |-> (run_q < RUN_W'(MAX_RUN))); // R7
    AST_HOLD_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> ($stable(wss_active) && $stable(wss_level))); // R10
endmodule

bind wss_inserter wss_inserter_chk #(
    .LINE_W(LINE_W), .LINE_SEL(LINE_SEL), .FRAME_LEN(wss_pkg::FRAME_LEN),
    .NUM_STD(NUM_STD), .DEN_STD(DEN_STD), .NUM_SQ(NUM_SQ), .DEN_SQ(DEN_SQ)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .field_first(field_first),
    .line_num(line_num), .wss_active(wss_active), .wss_level(wss_level)
);

// File: tb/wss_inserter_test.sv
module wss_inserter_test;
    localparam int OFS   = 264;
    localparam int LIMIT = OFS + 830;

    typedef struct packed {
        logic [9:0]  line;
        logic        field;
        logic        e1;
        logic        e2;
        logic        sel;
        logic [20:0] word;
        logic        burst;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{10'd23, 1'b1, 1'b1, 1'b0, 1'b0, {6'h3F, 14'h2D5A, 1'b1}, 1'b1},
        '{10'd23, 1'b1, 1'b1, 1'b1, 1'b1, {6'h00, 14'h1234, 1'b0}, 1'b1},
        '{10'd22, 1'b1, 1'b1, 1'b0, 1'b0, {6'h00, 14'h1234, 1'b0}, 1'b0},
        '{10'd23, 1'b0, 1'b1, 1'b1, 1'b0, {6'h00, 14'h1234, 1'b0}, 1'b0},
        '{10'd23, 1'b1, 1'b0, 1'b1, 1'b0, {6'h00, 14'h1234, 1'b0}, 1'b0},
        '{10'd24, 1'b1, 1'b1, 1'b0, 1'b1, {6'h00, 14'h1234, 1'b0}, 1'b0},
        '{10'd23, 1'b1, 1'b1, 1'b0, 1'b0, {6'h15, 14'h3FFF, 1'b0}, 1'b1},
        '{10'd23, 1'b1, 1'b1, 1'b0, 1'b1, {6'h2A, 14'h0000, 1'b1}, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_en = 1'b0;
    logic        field_first = 1'b0;
    logic [9:0]  line_num = '0;
    logic        en_f1 = 1'b0;
    logic        en_f2 = 1'b0;
    logic        clk_sel = 1'b0;
    logic [20:0] wss_word = '0;
    logic        wss_level, wss_active;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    wss_inserter #(.START_OFS(OFS)) uut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .field_first(field_first),
        .line_num(line_num), .en_f1(en_f1), .en_f2(en_f2), .clk_sel(clk_sel),
        .wss_word(wss_word), .wss_level(wss_level), .wss_active(wss_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit ref_elem(input int e, input logic [13:0] pay);
        logic [28:0] runin = 29'h1F1C71C7;
        logic [23:0] sync  = 24'h1E3C1F;
        int b, k;
        if (e < 29) return runin[28-e];
        if (e < 53) return sync[23-(e-29)];
        b = (e - 53) / 6;
        k = (e - 53) % 6;
        return pay[b] ? (k < 3) : (k >= 3);
    endfunction

    task automatic run_line(input vec_t v, input bit gap, input bit midchg);
        int s = 0, cyc = 0, first = -1, nact = 0, hold_bad = 0;
        int bad_pre = 0, bad_pay = 0, bad_tail = 0;
        int num = v.sel ? 10 : 5;
        int den = v.sel ? 59 : 27;
        int nlen = v.burst ? (137 * den + num - 1) / num : 0;
        bit strobe, la = 1'b0, ll = 1'b0, ea, el;
        int n, e;
        @(negedge clk);
        line_num = v.line; field_first = v.field; en_f1 = v.e1; en_f2 = v.e2;
        clk_sel = v.sel; wss_word = v.word; sample_en = 1'b1;
        while (s < LIMIT) begin
            @(posedge clk);
            strobe = sample_en;
            @(negedge clk);
            if (strobe) begin
                n = s - OFS - 1;
                ea = (n >= 0) && (n < nlen);
                e = ea ? (n * num) / den : 0;
                el = ea && ref_elem(e, v.word[14:1]);
                if (wss_active && first < 0) first = s;
                if (wss_active) nact++;
                if (wss_active !== ea || wss_level !== el) begin
                    if (!ea) bad_tail++;
                    else if (e < 53) bad_pre++;
                    else bad_pay++;
                end
                s++;
            end else if (wss_active !== la || wss_level !== ll) begin
                hold_bad++;
            end
            la = wss_active; ll = wss_level;
            if (midchg && s == OFS + 200) begin
                wss_word = ~v.word; clk_sel = ~v.sel;
            end
            cyc++;
            sample_en = gap ? ((cyc % 3) != 2) : 1'b1;
        end
        chk(first == (v.burst ? OFS + 1 : -1), "R8 start strobe", first, v.burst ? OFS + 1 : -1);
        chk(nact == nlen, "R2 R3 R7 active sample count", nact, nlen);
        chk(bad_pre == 0, "R4 run-in/start mismatches", bad_pre, 0);
        chk(bad_pay == 0, midchg ? "R9 R5 payload mismatches" : "R5 payload mismatches", bad_pay, 0);
        chk(bad_tail == 0, "R6 samples outside burst", bad_tail, 0);
        if (gap) chk(hold_bad == 0, "R10 change without strobe", hold_bad, 0);
        @(negedge clk);
        line_num = 10'd0; sample_en = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(wss_active == 1'b0, "R1 active in reset", int'(wss_active), 0);
        chk(wss_level == 1'b0, "R1 level in reset", int'(wss_level), 0);
        rst_n = 1'b1;
        sample_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(wss_active == 1'b0 && wss_level == 1'b0, "R1 outputs after reset",
            int'({wss_active, wss_level}), 0);

        for (int i = 0; i < 8; i++) begin
            run_line(VECS[i], 1'b0, 1'b0);
        end

        // Gapped strobes: hold between strobes and strobe-only counting (R10, R8).
        run_line(VECS[0], 1'b1, 1'b0);
        run_line(VECS[1], 1'b1, 1'b0);
        // Mid-line payload and clock-select change (R9).
        run_line(VECS[6], 1'b0, 1'b1);
        run_line(VECS[1], 1'b1, 1'b1);
        // Line 23 seen again after a field-2 line: field flag low, en_f2 set (R3).
        run_line(VECS[3], 1'b1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule